// File: doc/BRIEF.md
# NAND Bus Cycle Generator

This block produces one asynchronous NAND flash bus cycle per request. It drives chip enable, the command and address latch strobes, the write and read strobes, and the output enable of the 8-bit I/O bus. A sequencer above it issues requests. Each request is one of four kinds: latch a command byte, latch an address byte, write a data byte, or read a data byte. The sequencer decides which bytes make up a flash operation.

Each cycle has three phases: setup, strobe and hold. Their lengths come from configuration inputs as clock counts and are captured when the request is accepted. While a read is in progress, the controller stops driving the I/O bus so the flash device can drive it. The captured byte is presented on `rd_data`. The block also synchronises the open-drain ready/busy line into a busy flag, and drives the write-protect pin from a host-controlled level.

Top module: `nand_cycle_engine`

## Requirements
- R1: After reset the bus is idle: `nand_ce_n`=1, `nand_cle`=0, `nand_ale`=0, `nand_we_n`=1, `nand_re_n`=1, `nand_io_oe`=1, `req_ready`=1, `done`=0, `busy`=0, `nand_wp_n`=0, `rd_data`=0.
- R2: Kind 0 (command) raises `nand_cle` and keeps `nand_ale` low for the whole cycle, with chip enable low and one write strobe.
- R3: Kind 1 (address) raises `nand_ale` and keeps `nand_cle` low for the whole cycle, with one write strobe.
- R4: Kind 2 (data write) keeps both latch strobes low, pulses `nand_we_n` low, and drives the request byte on `nand_io_out` with `nand_io_oe`=1 for the whole cycle.
- R5: Kind 3 (data read) pulses `nand_re_n` low with `nand_we_n` high. `nand_io_oe` is 0 from the first setup cycle to the last hold cycle. `rd_data` takes the value `nand_io_in` had at the last clock edge of the strobe phase.
- R6: A cycle accepted at edge k lasts S+P+H clocks: setup in clocks 1..S, strobe in S+1..S+P, hold in S+P+1..S+P+H. S, P and H are `cfg_setup`, `cfg_pulse` and `cfg_hold` as sampled at acceptance, and any value below 2 counts as 2. When idle, CLE and ALE are low.
- R7: `done` is high for exactly the last hold clock. `req_ready` is low from the clock after acceptance until that hold clock ends. A request presented while `req_ready` is low is ignored.
- R8: `busy` equals the inverse of `nand_rb_n` delayed by two clock edges.
- R9: `nand_wp_n` equals the inverse of `wp_req` delayed by one clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request strobe, taken when `req_ready` is high |
| req_kind | input | 2 | 0 command, 1 address, 2 data write, 3 data read |
| req_data | input | 8 | Byte to send for kinds 0-2 |
| cfg_setup | input | CW | Setup phase length in clocks |
| cfg_pulse | input | CW | Strobe low length in clocks |
| cfg_hold | input | CW | Hold phase length in clocks |
| wp_req | input | 1 | Host write-protect request, 1 = protect |
| req_ready | output | 1 | Idle, request can be taken |
| done | output | 1 | One-clock end-of-cycle pulse |
| rd_data | output | 8 | Byte captured by the last read |
| busy | output | 1 | Synchronised device busy |
| nand_ce_n | output | 1 | Chip enable, active low |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_wp_n | output | 1 | Write protect, active low |
| nand_io_out | output | 8 | I/O bus output value |
| nand_io_oe | output | 1 | I/O bus output enable |
| nand_io_in | input | 8 | I/O bus input value |
| nand_rb_n | input | 1 | Ready/busy, low = busy |

## Verification
Pin states are due in the first clock after the accepting edge and then follow the phase boundaries S, S+P and S+P+H, counted in clocks from that edge. `rd_data` changes at the edge that ends the strobe phase. `busy` trails `nand_rb_n` by two edges and `nand_wp_n` trails `wp_req` by one. The bench's reference model advances on each rising edge with the same latencies written as counters and delay variables. Every output is compared with it at the falling edge that follows, when all registered values have settled.

// File: rtl/nand_cycle_engine.sv
module nand_cycle_engine #(
  parameter int CW = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [1:0]    req_kind,
  input  logic [DW-1:0] req_data,
  input  logic [CW-1:0] cfg_setup,
  input  logic [CW-1:0] cfg_pulse,
  input  logic [CW-1:0] cfg_hold,
  input  logic          wp_req,
  output logic          req_ready,
  output logic          done,
  output logic [DW-1:0] rd_data,
  output logic          busy,
  output logic          nand_ce_n,
  output logic          nand_cle,
  output logic          nand_ale,
  output logic          nand_we_n,
  output logic          nand_re_n,
  output logic          nand_wp_n,
  output logic [DW-1:0] nand_io_out,
  output logic          nand_io_oe,
  input  logic [DW-1:0] nand_io_in,
  input  logic          nand_rb_n
);
  localparam logic [1:0] K_CMD = 2'd0;
  localparam logic [1:0] K_ADR = 2'd1;
  localparam logic [1:0] K_RD  = 2'd3;
  localparam logic [CW-1:0] MIN_T = CW'(2);

  typedef enum logic [1:0] {IDLE, SETUP, STROBE, HOLD} phase_t;

  phase_t        ph;
  logic [CW-1:0] cnt, len_p, len_h;
  logic [1:0]    kind;
  logic [DW-1:0] dat;
  logic [1:0]    rb_s;
  logic          wp_q;

  function automatic logic [CW-1:0] clamp(input logic [CW-1:0] v);
    return (v < MIN_T) ? MIN_T : v;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph      <= IDLE;
      cnt     <= '0;
      len_p   <= MIN_T;
      len_h   <= MIN_T;
      kind    <= K_CMD;
      dat     <= '0;
      rd_data <= '0;
    end else begin
      case (ph)
        IDLE: if (req_valid) begin
          ph    <= SETUP;
          cnt   <= clamp(cfg_setup) - CW'(1);
          len_p <= clamp(cfg_pulse);
          len_h <= clamp(cfg_hold);
          kind  <= req_kind;
          dat   <= req_data;
        end
        SETUP: if (cnt == '0) begin
          ph  <= STROBE;
          cnt <= len_p - CW'(1);
        end else cnt <= cnt - CW'(1);
        STROBE: if (cnt == '0) begin
          ph  <= HOLD;
          cnt <= len_h - CW'(1);
          if (kind == K_RD) rd_data <= nand_io_in;
        end else cnt <= cnt - CW'(1);
        default: if (cnt == '0) ph <= IDLE;
                 else cnt <= cnt - CW'(1);
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rb_s <= 2'b11;
      wp_q <= 1'b0;
    end else begin
      rb_s <= {rb_s[0], nand_rb_n};
      wp_q <= ~wp_req;
    end
  end

  logic act, rd_k, strobe;
  assign act    = (ph != IDLE);
  assign rd_k   = (kind == K_RD);
  assign strobe = (ph == STROBE);

  assign req_ready   = ~act;
  assign done        = (ph == HOLD) && (cnt == '0);
  assign nand_ce_n   = ~act;
  assign nand_cle    = act && (kind == K_CMD);
  assign nand_ale    = act && (kind == K_ADR);
  assign nand_we_n   = ~(strobe && !rd_k);
  assign nand_re_n   = ~(strobe && rd_k);
  assign nand_io_oe  = ~(act && rd_k);
  assign nand_io_out = dat;
  assign busy        = ~rb_s[1];
  assign nand_wp_n   = wp_q;
endmodule

module nand_cycle_engine_chk (
  input logic clk,
  input logic rst_n,
  input logic wp_req,
  input logic req_ready,
  input logic done,
  input logic nand_ce_n,
  input logic nand_cle,
  input logic nand_ale,
  input logic nand_we_n,
  input logic nand_re_n,
  input logic nand_wp_n,
  input logic nand_io_oe
);
  p_idle_pins_r1: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (nand_ce_n && !nand_cle && !nand_ale && nand_we_n && nand_re_n));
  p_latch_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(nand_cle && nand_ale));
  p_strobe_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(!nand_we_n && !nand_re_n));
  p_bus_free_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !nand_re_n |-> !nand_io_oe);
  p_oe_early_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(nand_re_n) |-> !$past(nand_io_oe));
  p_done_once_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_done_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> req_ready);
  p_wp_follow_r9: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (nand_wp_n == !$past(wp_req)));
endmodule

bind nand_cycle_engine nand_cycle_engine_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wp_req(wp_req), .req_ready(req_ready),
  .done(done), .nand_ce_n(nand_ce_n), .nand_cle(nand_cle),
  .nand_ale(nand_ale), .nand_we_n(nand_we_n), .nand_re_n(nand_re_n),
  .nand_wp_n(nand_wp_n), .nand_io_oe(nand_io_oe)
);

// File: tb/nand_cycle_engine_test.sv
module nand_cycle_engine_test;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic       rst_n = 1'b0;
  logic       req_valid = 1'b0;
  logic [1:0] req_kind = 2'd0;
  logic [7:0] req_data = 8'h00;
  logic [7:0] cfg_setup = 8'd2, cfg_pulse = 8'd2, cfg_hold = 8'd2;
  logic       wp_req = 1'b1;
  logic [7:0] nand_io_in = 8'h00;
  logic       nand_rb_n = 1'b1;
  logic       req_ready, done, busy;
  logic [7:0] rd_data, nand_io_out;
  logic       nand_ce_n, nand_cle, nand_ale, nand_we_n, nand_re_n, nand_wp_n, nand_io_oe;

  nand_cycle_engine uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
    .req_data(req_data), .cfg_setup(cfg_setup), .cfg_pulse(cfg_pulse),
    .cfg_hold(cfg_hold), .wp_req(wp_req), .req_ready(req_ready), .done(done),
    .rd_data(rd_data), .busy(busy), .nand_ce_n(nand_ce_n), .nand_cle(nand_cle),
    .nand_ale(nand_ale), .nand_we_n(nand_we_n), .nand_re_n(nand_re_n),
    .nand_wp_n(nand_wp_n), .nand_io_out(nand_io_out), .nand_io_oe(nand_io_oe),
    .nand_io_in(nand_io_in), .nand_rb_n(nand_rb_n)
  );

  int total = 0, bad = 0;

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s at %0t: actual=%0h expected=%0h", tag, $time, act, exp);
    end
  endtask

  // reference model
  bit m_act = 0;
  int m_t = 0, m_s = 2, m_p = 2, m_h = 2, m_kind = 0, m_data = 0, m_rd = 0;
  bit m_rb1 = 1, m_rb2 = 1, m_wp = 0;

  function automatic int clampv(input int v);
    return (v < 2) ? 2 : v;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_act = 0; m_t = 0; m_rd = 0; m_rb1 = 1; m_rb2 = 1; m_wp = 0;
    end else begin
      m_rb2 = m_rb1; m_rb1 = nand_rb_n; m_wp = !wp_req;
      if (m_act) begin
        if (m_kind == 3 && m_t == m_s + m_p) m_rd = nand_io_in;
        if (m_t == m_s + m_p + m_h) m_act = 0;
        else m_t++;
      end else if (req_valid) begin
        m_act = 1; m_t = 1;
        m_s = clampv(cfg_setup); m_p = clampv(cfg_pulse); m_h = clampv(cfg_hold);
        m_kind = req_kind; m_data = req_data;
      end
    end
  end

  bit compare_on = 0;
  always @(negedge clk) begin
    if (compare_on) begin
      bit in_strobe;
      in_strobe = m_act && m_t > m_s && m_t <= m_s + m_p;
      chk("R6 ce_n", nand_ce_n, !m_act);
      chk("R2 cle", nand_cle, m_act && m_kind == 0);
      chk("R3 ale", nand_ale, m_act && m_kind == 1);
      chk("R4 we_n", nand_we_n, !(in_strobe && m_kind != 3));
      chk("R5 re_n", nand_re_n, !(in_strobe && m_kind == 3));
      chk("R5 io_oe", nand_io_oe, !(m_act && m_kind == 3));
      if (m_act && m_kind != 3) chk("R4 io_out", nand_io_out, m_data);
      chk("R5 rd_data", rd_data, m_rd);
      chk("R7 done", done, m_act && m_t == m_s + m_p + m_h);
      chk("R7 ready", req_ready, !m_act);
      chk("R8 busy", busy, !m_rb2);
      chk("R9 wp_n", nand_wp_n, m_wp);
    end
  end

  task automatic issue(input int kind, input int data, input int s, input int p, input int h);
    @(negedge clk);
    req_valid = 1; req_kind = 2'(kind); req_data = 8'(data);
    cfg_setup = 8'(s); cfg_pulse = 8'(p); cfg_hold = 8'(h);
    @(negedge clk);
    req_valid = 0;
    for (int i = 0; i < 2000 && !req_ready; i++) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 ce_n", nand_ce_n, 1); chk("R1 cle", nand_cle, 0); chk("R1 ale", nand_ale, 0);
    chk("R1 we_n", nand_we_n, 1); chk("R1 re_n", nand_re_n, 1); chk("R1 io_oe", nand_io_oe, 1);
    chk("R1 ready", req_ready, 1); chk("R1 done", done, 0); chk("R1 busy", busy, 0);
    chk("R1 wp_n", nand_wp_n, 0); chk("R1 rd_data", rd_data, 0);
    rst_n = 1;
    @(negedge clk);
    compare_on = 1;
    issue(0, 8'h70, 2, 3, 2);
    issue(1, 8'h12, 4, 2, 5);
    issue(2, 8'hC3, 0, 1, 2);
    wp_req = 0;
    nand_io_in = 8'hA5;
    issue(3, 0, 3, 4, 2);
    nand_rb_n = 0;
    @(negedge clk); @(negedge clk);
    nand_rb_n = 1;
    nand_io_in = 8'h3C;
    // R7 request while active is ignored
    @(negedge clk);
    req_valid = 1; req_kind = 2'd2; req_data = 8'h55;
    cfg_setup = 8'd5; cfg_pulse = 8'd5; cfg_hold = 8'd5;
    @(negedge clk);
    req_valid = 0;
    repeat (3) @(negedge clk);
    req_valid = 1; req_kind = 2'd0; req_data = 8'hFF;
    @(negedge clk);
    req_valid = 0;
    for (int i = 0; i < 100 && !req_ready; i++) @(negedge clk);
    issue(3, 0, 1, 0, 3);
    wp_req = 1;
    issue(0, 8'hD0, 6, 2, 2);
    repeat (5) @(negedge clk);
    compare_on = 0;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule